// File: doc/BRIEF.md
# Local Interrupt Priority Acceptance Unit

This block sits beside one processor core and decides which pending interrupt vector the core should take. It keeps a 256-bit pending vector set, a 256-bit in-service vector set, a task priority and a spurious-vector register. Vector numbers are 8 bits wide. The upper four bits of a vector number form its priority class. A set pulse from the interrupt bus marks a vector pending. The unit raises its request line to the core when the highest pending vector has a higher class than the current processor priority.

The core answers the request with an acknowledge strobe. One cycle later the unit returns a vector on a valid/data pair. The core signals the end of a handler with an end-of-interrupt strobe, which retires the highest in-service vector. Finding the highest set bit of each 256-bit set is split over two clock cycles. After any change to either set, the unit lowers a ready flag for one cycle. Acknowledge and end-of-interrupt are accepted only while this flag is high.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset no vector is pending or in service, the task priority is 0, the spurious register holds 0x0FF (enable bit 8 clear, vector 0xFF), irq_o is low, ack_ready_o is high and ppr_o is 0.
- R2: A cycle with set_vld_i high marks vector set_vec_i pending. The candidate vector is the highest-numbered pending vector.
- R3: irq_o is never high while bit 8 of the spurious register is clear. A spurious write stores all 9 bits of spur_val_i.
- R4: irq_o is high exactly when ack_ready_o is high, the enable bit is set, a vector is pending, and either ppr_o is 0 or the class (bits 7:4) of the candidate is greater than the class of ppr_o.
- R5: A task-priority write stores tpr_val_i in bits 7:4 of the 8-bit task priority, with bits 3:0 zero.
- R6: ppr_o equals the task priority when the task priority's class is at least the class of the highest in-service vector (0 when none is in service). Otherwise ppr_o is that in-service class in bits 7:4 with bits 3:0 zero.
- R7: An accepted acknowledge drives ack_vld_o high in the next cycle. It clears the candidate's pending bit, and in the normal case sets its in-service bit and returns the candidate on ack_vec_o.
- R8: If the task priority is nonzero and the candidate is less than or equal to it as an 8-bit number, an acknowledge clears the pending bit, leaves the in-service set unchanged and returns bits 7:0 of the spurious register.
- R9: An acknowledge with no vector pending returns bits 7:0 of the spurious register and changes no state.
- R10: An accepted end-of-interrupt clears the highest in-service bit. With nothing in service it has no effect.
- R11: ack_ready_o is low for the one cycle after any change to the pending or in-service set. Acknowledge and end-of-interrupt presented while it is low are ignored, and ack_vld_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_vld_i | input | 1 | Vector-set pulse from the bus |
| set_vec_i | input | 8 | Vector to mark pending |
| tpr_wr_i | input | 1 | Task priority write strobe |
| tpr_val_i | input | 4 | Task priority class to store |
| spur_wr_i | input | 1 | Spurious register write strobe |
| spur_val_i | input | 9 | Enable bit 8 and spurious vector 7:0 |
| ack_req_i | input | 1 | Acknowledge strobe from the core |
| eoi_i | input | 1 | End-of-interrupt strobe |
| ack_ready_o | output | 1 | Search results current; strobes accepted |
| ack_vld_o | output | 1 | Returned vector valid |
| ack_vec_o | output | 8 | Returned vector |
| irq_o | output | 1 | Interrupt request to the core |
| ppr_o | output | 8 | Current processor priority |

## Verification
Directed steps first show that the enable bit alone decides whether a pending vector raises the request. They then show that a pending vector in the same class as an in-service vector is held back, and that the same vector is released once the end-of-interrupt retires the in-service vector. A task priority at or above a pending vector separates the spurious return from a normal acknowledge. An acknowledge made during the stale cycle separates correct gating from a result taken from the old search. Random mixes of sets, task-priority and spurious writes, acknowledges and end-of-interrupts then compare the request line, the processor priority and every returned vector against a bench model. These mixes include sets landing in words other than the top one and repeats of vectors already pending.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
    localparam int NUM_VEC   = 256;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = NUM_VEC / WORD_W;
    localparam int VEC_W     = $clog2(NUM_VEC);
    localparam int CLS_W     = 4;
    localparam int SPUR_W    = VEC_W + 1;

    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        vec_t               tpr;
        logic [SPUR_W-1:0]  spur;
        logic               stale;
        logic               ack_vld;
        vec_t               ack_vec;
    } unit_state_t;
endpackage

// File: rtl/irq_word_enc.sv
module irq_word_enc #(
    parameter int W = 32,
    localparam int POS_W = $clog2(W)
) (
    input  logic [W-1:0]     word_i,
    output logic             hit_o,
    output logic [POS_W-1:0] pos_o
);
    always_comb begin
        hit_o = |word_i;
        pos_o = '0;
        for (int i = 0; i < W; i++) begin
            if (word_i[i]) pos_o = POS_W'(i);
        end
    end
endmodule

// File: rtl/irq_vec_search.sv
module irq_vec_search #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    localparam int POS_W  = $clog2(WORD_W),
    localparam int WSEL_W = $clog2(NUM_WORDS),
    localparam int IDX_W  = POS_W + WSEL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_WORDS*WORD_W-1:0] bits_i,
    output logic                        found_o,
    output logic [IDX_W-1:0]            top_o
);
    logic [NUM_WORDS-1:0]            hit_d, hit_q;
    logic [NUM_WORDS-1:0][POS_W-1:0] pos_d, pos_q;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        irq_word_enc #(.W(WORD_W)) u_enc (
            .word_i (bits_i[w*WORD_W +: WORD_W]),
            .hit_o  (hit_d[w]),
            .pos_o  (pos_d[w])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= '0;
            pos_q <= '0;
        end else begin
            hit_q <= hit_d;
            pos_q <= pos_d;
        end
    end

    // The highest word with a hit wins; later iterations overwrite earlier ones.
    always_comb begin
        found_o = |hit_q;
        top_o   = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (hit_q[w]) top_o = {WSEL_W'(w), pos_q[w]};
        end
    end
endmodule

// File: rtl/irq_prio_calc.sv
module irq_prio_calc #(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4,
    localparam int SUB_W = VEC_W - CLS_W
) (
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             isr_found_i,
    input  logic [VEC_W-1:0] isr_top_i,
    output logic [VEC_W-1:0] ppr_o
);
    logic [CLS_W-1:0] isr_cls;

    always_comb begin
        isr_cls = isr_found_i ? isr_top_i[VEC_W-1 -: CLS_W] : '0;
        if (tpr_i[VEC_W-1 -: CLS_W] >= isr_cls) ppr_o = tpr_i;
        else                                    ppr_o = {isr_cls, {SUB_W{1'b0}}};
    end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_vld_i,
    input  logic [VEC_W-1:0]  set_vec_i,
    input  logic              tpr_wr_i,
    input  logic [CLS_W-1:0]  tpr_val_i,
    input  logic              spur_wr_i,
    input  logic [SPUR_W-1:0] spur_val_i,
    input  logic              ack_req_i,
    input  logic              eoi_i,
    output logic              ack_ready_o,
    output logic              ack_vld_o,
    output logic [VEC_W-1:0]  ack_vec_o,
    output logic              irq_o,
    output logic [VEC_W-1:0]  ppr_o
);
    localparam int SUB_W = VEC_W - CLS_W;

    unit_state_t st_d, st_q;
    logic irr_found, isr_found;
    vec_t irr_top, isr_top, ppr_w;
    logic ready;

    irq_vec_search #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_irr_search (
        .clk(clk), .rst_n(rst_n), .bits_i(st_q.irr),
        .found_o(irr_found), .top_o(irr_top)
    );

    irq_vec_search #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_isr_search (
        .clk(clk), .rst_n(rst_n), .bits_i(st_q.isr),
        .found_o(isr_found), .top_o(isr_top)
    );

    irq_prio_calc #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_prio (
        .tpr_i(st_q.tpr), .isr_found_i(isr_found), .isr_top_i(isr_top),
        .ppr_o(ppr_w)
    );

    assign ready = !st_q.stale;

    always_comb begin
        st_d = st_q;
        st_d.ack_vld = 1'b0;
        if (tpr_wr_i) st_d.tpr  = {tpr_val_i, {SUB_W{1'b0}}};
        if (spur_wr_i) st_d.spur = spur_val_i;
        if (eoi_i && ready && isr_found) st_d.isr[isr_top] = 1'b0;
        if (ack_req_i && ready) begin
            st_d.ack_vld = 1'b1;
            if (!irr_found) begin
                st_d.ack_vec = st_q.spur[VEC_W-1:0];
            end else begin
                st_d.irr[irr_top] = 1'b0;
                if (st_q.tpr != '0 && irr_top <= st_q.tpr) begin
                    st_d.ack_vec = st_q.spur[VEC_W-1:0];
                end else begin
                    st_d.isr[irr_top] = 1'b1;
                    st_d.ack_vec      = irr_top;
                end
            end
        end
        if (set_vld_i) st_d.irr[set_vec_i] = 1'b1;
        st_d.stale = (st_d.irr != st_q.irr) || (st_d.isr != st_q.isr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.spur <= SPUR_W'(9'h0FF);
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_ready_o = ready;
    assign ack_vld_o   = st_q.ack_vld;
    assign ack_vec_o   = st_q.ack_vec;
    assign ppr_o       = ppr_w;
    assign irq_o       = ready && st_q.spur[VEC_W] && irr_found &&
                         (ppr_w == '0 ||
                          irr_top[VEC_W-1 -: CLS_W] > ppr_w[VEC_W-1 -: CLS_W]);

    assert_irq_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> st_q.spur[VEC_W]);

    assert_irq_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (st_q.irr[irr_top] && !st_q.stale));

    assert_search_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && irr_found) |-> ((st_q.irr >> irr_top) == NUM_VEC'(1)));

    assert_search_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !irr_found) |-> (st_q.irr == '0));

    assert_ppr_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && isr_found) |-> (ppr_w[VEC_W-1 -: CLS_W] >= isr_top[VEC_W-1 -: CLS_W]));

    assert_ack_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld_o |-> ($past(ack_req_i) && !$past(st_q.stale)));

    assert_eoi_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && ready && isr_found && !ack_req_i) |=> !st_q.isr[$past(isr_top)]);
endmodule

// File: tb/irq_accept_unit_bench.sv
`timescale 1ns/1ps
module irq_accept_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_vld = 1'b0;
    logic [7:0] set_vec = '0;
    logic       tpr_wr = 1'b0;
    logic [3:0] tpr_val = '0;
    logic       spur_wr = 1'b0;
    logic [8:0] spur_val = '0;
    logic       ack_req = 1'b0;
    logic       eoi = 1'b0;
    logic       ack_ready, ack_vld, irq;
    logic [7:0] ack_vec, ppr;

    int n_chk = 0;
    int n_fail = 0;

    logic [255:0] m_irr, m_isr;
    int           m_tpr;
    logic [8:0]   m_spur;

    always #2.5 clk = ~clk;

    irq_accept_unit u_irq_accept_unit (
        .clk(clk), .rst_n(rst_n),
        .set_vld_i(set_vld), .set_vec_i(set_vec),
        .tpr_wr_i(tpr_wr), .tpr_val_i(tpr_val),
        .spur_wr_i(spur_wr), .spur_val_i(spur_val),
        .ack_req_i(ack_req), .eoi_i(eoi),
        .ack_ready_o(ack_ready), .ack_vld_o(ack_vld), .ack_vec_o(ack_vec),
        .irq_o(irq), .ppr_o(ppr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int top_of(input logic [255:0] v);
        for (int i = 255; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    function automatic int exp_ppr();
        int t = top_of(m_isr);
        int c = (t >= 0) ? (t >> 4) : 0;
        if ((m_tpr >> 4) >= c) return m_tpr;
        return c << 4;
    endfunction

    function automatic int exp_irq();
        int t = top_of(m_irr);
        int p = exp_ppr();
        if (!m_spur[8] || t < 0) return 0;
        if (p != 0 && (t >> 4) <= (p >> 4)) return 0;
        return 1;
    endfunction

    function automatic int model_ack();
        int t = top_of(m_irr);
        if (t < 0) return int'(m_spur[7:0]);
        m_irr[t] = 1'b0;
        if (m_tpr != 0 && t <= m_tpr) return int'(m_spur[7:0]);
        m_isr[t] = 1'b1;
        return t;
    endfunction

    // R4 R6: request line and processor priority against the model
    task automatic check_state(input string tag);
        chk(ack_ready == 1'b1, {tag, " R11 ready"}, int'(ack_ready), 1);
        chk(int'(irq) == exp_irq(), {tag, " R4 irq"}, int'(irq), exp_irq());
        chk(int'(ppr) == exp_ppr(), {tag, " R6 ppr"}, int'(ppr), exp_ppr());
    endtask

    task automatic op_set(input int v);
        set_vld = 1'b1; set_vec = 8'(v);
        @(negedge clk);
        set_vld = 1'b0;
        m_irr[v] = 1'b1;
        @(negedge clk);
    endtask

    task automatic op_tpr(input int c);
        tpr_wr = 1'b1; tpr_val = 4'(c);
        @(negedge clk);
        tpr_wr = 1'b0;
        m_tpr = c << 4;
        @(negedge clk);
    endtask

    task automatic op_spur(input int s);
        spur_wr = 1'b1; spur_val = 9'(s);
        @(negedge clk);
        spur_wr = 1'b0;
        m_spur = 9'(s);
        @(negedge clk);
    endtask

    task automatic op_ack(input string tag);
        int e;
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        e = model_ack();
        chk(ack_vld == 1'b1, {tag, " R7 ack_vld"}, int'(ack_vld), 1);
        chk(int'(ack_vec) == e, {tag, " R7 R8 vector"}, int'(ack_vec), e);
        @(negedge clk);
    endtask

    task automatic op_eoi();
        int t = top_of(m_isr);
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
        if (t >= 0) m_isr[t] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_irr = '0; m_isr = '0; m_tpr = 0; m_spur = 9'h0FF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);
        chk(ack_ready == 1'b1, "R1 ready", int'(ack_ready), 1);
        chk(ppr == 8'h00, "R1 ppr", int'(ppr), 0);
        chk(ack_vld == 1'b0, "R1 ack_vld", int'(ack_vld), 0);
        // R9 R1: empty acknowledge returns reset spurious vector 0xFF
        op_ack("R9 R1 empty");
        check_state("R9 after empty ack");
        // R11: ready drops for one cycle after a new pending bit
        set_vld = 1'b1; set_vec = 8'h45;
        @(negedge clk);
        set_vld = 1'b0; m_irr[8'h45] = 1'b1;
        chk(ack_ready == 1'b0, "R11 stale", int'(ack_ready), 0);
        @(negedge clk);
        // R3: disabled, no request
        chk(irq == 1'b0, "R3 disabled", int'(irq), 0);
        check_state("R3");
        op_spur(9'h13F);
        chk(irq == 1'b1, "R3 enabled", int'(irq), 1);
        check_state("R3 enabled");
        // R2 R7: highest pending taken
        op_set(8'h47);
        op_set(8'h20);
        op_ack("R2 R7 top");
        chk(ppr == 8'h40, "R6 class of in-service", int'(ppr), 8'h40);
        chk(irq == 1'b0, "R4 same class held", int'(irq), 0);
        check_state("R4");
        // R10: EOI releases
        op_eoi();
        chk(ppr == 8'h00, "R10 eoi ppr", int'(ppr), 0);
        chk(irq == 1'b1, "R10 eoi irq", int'(irq), 1);
        // R5 R8: task priority and spurious return
        op_tpr(5);
        chk(ppr == 8'h50, "R5 tpr nibble", int'(ppr), 8'h50);
        check_state("R5");
        op_ack("R8 spurious");
        check_state("R8 isr untouched");
        // R11: acknowledge during stale cycle ignored
        set_vld = 1'b1; set_vec = 8'h90;
        @(negedge clk);
        set_vld = 1'b0; m_irr[8'h90] = 1'b1;
        ack_req = 1'b1; eoi = 1'b1;
        @(negedge clk);
        ack_req = 1'b0; eoi = 1'b0;
        chk(ack_vld == 1'b0, "R11 ack ignored", int'(ack_vld), 0);
        @(negedge clk);
        check_state("R11 state kept");
        // R10: EOI with nothing in service has no effect
        op_tpr(0);
        op_eoi();
        check_state("R10 empty eoi");
        // random mix
        for (int k = 0; k < 600; k++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 40)      op_set(int'($urandom_range(0, 255)));
            else if (r < 50) op_tpr(int'($urandom_range(0, 15)));
            else if (r < 55) op_spur(int'({($urandom_range(0, 3) != 0), 8'($urandom_range(0, 255))}));
            else if (r < 80) op_ack("R7 random");
            else             op_eoi();
            check_state("random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule